// File: doc/BRIEF.md
# Starvation-Aware Memory Request Scheduler

This block collects read and write requests from four client ports. It sorts them into three first-in, first-out queues: urgent reads, background reads and writes. Each cycle it offers one request to a downstream memory command interface. A per-port enable bit decides whether that port's reads are urgent. Reads from all other ports are background reads. The two read queues share a fixed pool of 32 entries. A configuration count sets how many of those entries belong to urgent reads, and the background queue gets the rest.

Each queue has an age counter that runs while the queue holds work and is not being served. When the counter reaches the queue's programmed level times 32 cycles, the queue becomes critical and is served before every non-critical queue. A small level therefore raises a queue's effective priority. Requests enter through a round-robin selector, one per cycle. A port sees backpressure while the queue its request would enter is at its share of entries. Configuration inputs may change only while all three queues are empty.

Top module: `mem_req_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cmd_valid` is 0, and `req_ready` is 0 while no request is offered.
- R2: A request with its write bit set enters the write queue. A read from port p enters the urgent queue when `cfg_hi_port[p]` is 1 and the background queue when it is 0. Each issued command shows its queue: `cmd_hi`=1 and `cmd_write`=0 for urgent reads, `cmd_write`=1 and `cmd_hi`=0 for writes, and both 0 for background reads.
- R3: The urgent read queue holds at most min(`cfg_hi_slots`,32) entries and the background read queue holds at most 32 minus that. The write queue holds 16 entries. A port whose target queue is at this limit is not given ready.
- R4: A `cfg_hi_slots` value above 32 acts as 32, which leaves no entries for background reads.
- R5: A queue's age counter is cleared in any cycle in which the queue is empty or its head is issued. Otherwise it counts up by one per cycle. The queue is critical once the counter is at least its level × 32.
- R6: When any queue is critical, the command comes from a critical queue. Otherwise it comes from any non-empty queue. In both cases ties go in the order urgent read, write, background read.
- R7: At most one port gets ready per cycle. The search starts at the port after the last one accepted (port 0 after reset) and wraps around, and it takes the first port that is valid and has room.
- R8: Commands from each queue leave in the order the requests entered it, with their id and address unchanged.
- R9: `cmd_valid` stays high while `cmd_ready` is low. An entry leaves only on a cycle with both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hi_port | input | 4 | Per-port enable: reads from this port are urgent |
| cfg_hi_slots | input | 6 | Read entries given to the urgent class (clamped to 32) |
| cfg_lvl_hi | input | 4 | Critical level of the urgent read queue, in units of 32 cycles |
| cfg_lvl_wr | input | 4 | Critical level of the write queue |
| cfg_lvl_lo | input | 4 | Critical level of the background read queue |
| req_valid | input | 4 | Request valid, one bit per port |
| req_write | input | 4 | Request is a write, one bit per port |
| req_id | input | 16 | Request ids, 4 bits per port, port 0 in the low bits |
| req_addr | input | 64 | Request addresses, 16 bits per port, port 0 in the low bits |
| req_ready | output | 4 | Request accepted this cycle, one bit per port |
| cmd_valid | output | 1 | A command is offered downstream |
| cmd_ready | input | 1 | Downstream takes the command |
| cmd_write | output | 1 | Offered command comes from the write queue |
| cmd_hi | output | 1 | Offered command comes from the urgent read queue |
| cmd_id | output | 4 | Id of the offered command |
| cmd_addr | output | 16 | Address of the offered command |

## Verification
Two functions can fall in the same cycle: admission into a queue and issue from that same queue. A third can join them, because a queue's age may reach its critical threshold in a cycle where a higher-order queue also has work. The critical-level test keeps the urgent queue both filling and draining on every cycle while one background read ages. The expected issue cycle of that read is exactly its level times 32 plus one cycle after admission. Random traffic with small levels and random downstream stalls provokes many push-and-pop and critical-override collisions. Every cycle is judged against a behavioural queue model that predicts `req_ready`, `cmd_valid` and the offered command.

// File: rtl/mem_req_sched.sv
module mem_req_sched #(
  parameter int NP       = 4,
  parameter int IDW      = 4,
  parameter int AW       = 16,
  parameter int RD_TOTAL = 32,
  parameter int WR_DEPTH = 16,
  parameter int LVLW     = 4,
  parameter int UNIT     = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NP-1:0]             cfg_hi_port,
  input  logic [$clog2(RD_TOTAL):0] cfg_hi_slots,
  input  logic [LVLW-1:0]           cfg_lvl_hi,
  input  logic [LVLW-1:0]           cfg_lvl_wr,
  input  logic [LVLW-1:0]           cfg_lvl_lo,
  input  logic [NP-1:0]             req_valid,
  input  logic [NP-1:0]             req_write,
  input  logic [NP*IDW-1:0]         req_id,
  input  logic [NP*AW-1:0]          req_addr,
  output logic [NP-1:0]             req_ready,
  output logic                      cmd_valid,
  input  logic                      cmd_ready,
  output logic                      cmd_write,
  output logic                      cmd_hi,
  output logic [IDW-1:0]            cmd_id,
  output logic [AW-1:0]             cmd_addr
);
  localparam int PW   = $clog2(RD_TOTAL);
  localparam int CW   = PW + 1;
  localparam int SW   = LVLW + $clog2(UNIT) + 1;
  localparam int EW   = IDW + AW;
  localparam int SELW = (NP > 1) ? $clog2(NP) : 1;
  localparam logic [SW-1:0] AGE_MAX = '1;

  // queue index 0: urgent reads, 1: writes, 2: background reads
  logic [EW-1:0]   mem [3][RD_TOTAL];
  logic [PW-1:0]   wp  [3];
  logic [PW-1:0]   rp  [3];
  logic [CW-1:0]   cnt [3];
  logic [SW-1:0]   age [3];
  logic [CW-1:0]   cap [3];
  logic [SW-1:0]   lim [3];
  logic [1:0]      dq  [NP];
  logic [CW-1:0]   hcap;
  logic [NP-1:0]   elig;
  logic [SELW-1:0] rr, sel;
  logic            acc, pop;
  logic [2:0]      ne, crit, psh_v, pop_v;
  logic [1:0]      pick;
  logic [EW-1:0]   head, entry;

  assign hcap   = (cfg_hi_slots > CW'(RD_TOTAL)) ? CW'(RD_TOTAL) : cfg_hi_slots;
  assign cap[0] = hcap;
  assign cap[1] = CW'(WR_DEPTH);
  assign cap[2] = CW'(RD_TOTAL) - hcap;
  assign lim[0] = SW'(cfg_lvl_hi) * SW'(UNIT);
  assign lim[1] = SW'(cfg_lvl_wr) * SW'(UNIT);
  assign lim[2] = SW'(cfg_lvl_lo) * SW'(UNIT);

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      dq[p]   = req_write[p] ? 2'd1 : (cfg_hi_port[p] ? 2'd0 : 2'd2);
      elig[p] = req_valid[p] && (cnt[dq[p]] < cap[dq[p]]);
    end
  end

  always_comb begin
    acc = 1'b0;
    sel = rr;
    for (int k = 0; k < NP; k++) begin
      if (!acc && elig[(int'(rr) + k) % NP]) begin
        acc = 1'b1;
        sel = SELW'((int'(rr) + k) % NP);
      end
    end
    req_ready = '0;
    if (acc) req_ready[sel] = 1'b1;
  end

  assign entry = {req_id[int'(sel)*IDW +: IDW], req_addr[int'(sel)*AW +: AW]};

  always_comb begin
    for (int q = 0; q < 3; q++) begin
      ne[q]   = cnt[q] != '0;
      crit[q] = ne[q] && (age[q] >= lim[q]);
    end
    pick = 2'd0;
    for (int q = 2; q >= 0; q--)
      if ((crit != 3'b000) ? crit[q] : ne[q]) pick = 2'(q);
  end

  assign head      = mem[pick][rp[pick]];
  assign cmd_valid = |ne;
  assign pop       = cmd_valid && cmd_ready;
  assign cmd_write = pick == 2'd1;
  assign cmd_hi    = pick == 2'd0;
  assign cmd_id    = head[EW-1:AW];
  assign cmd_addr  = head[AW-1:0];

  always_comb begin
    for (int q = 0; q < 3; q++) begin
      psh_v[q] = acc && (dq[sel] == 2'(q));
      pop_v[q] = pop && (pick == 2'(q));
    end
  end

  always_ff @(posedge clk) begin
    for (int q = 0; q < 3; q++)
      if (psh_v[q]) mem[q][wp[q]] <= entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr <= '0;
      for (int q = 0; q < 3; q++) begin
        wp[q]  <= '0;
        rp[q]  <= '0;
        cnt[q] <= '0;
        age[q] <= '0;
      end
    end else begin
      if (acc) rr <= SELW'((int'(sel) + 1) % NP);
      for (int q = 0; q < 3; q++) begin
        if (psh_v[q]) wp[q] <= wp[q] + PW'(1);
        if (pop_v[q]) rp[q] <= rp[q] + PW'(1);
        cnt[q] <= cnt[q] + CW'(psh_v[q]) - CW'(pop_v[q]);
        if (pop_v[q] || !ne[q]) age[q] <= '0;
        else if (age[q] != AGE_MAX) age[q] <= age[q] + SW'(1);
      end
    end
  end

  p_share_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt[0] <= cap[0] && cnt[1] <= cap[1] && cnt[2] <= cap[2]);

  p_single_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  p_hold_offer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid);

  p_background_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_write && !cmd_hi |-> (cnt[0] == '0 && cnt[1] == '0) || crit[2]);
endmodule

// File: tb/mem_req_sched_tb_top.sv
`timescale 1ns/1ps
module mem_req_sched_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  hi_port = 4'b1000;
  logic [5:0]  hi_slots = 6'd24;
  logic [3:0]  lv_hi = 4'd2, lv_wr = 4'd15, lv_lo = 4'd15;
  logic [3:0]  rv = '0, rw = '0;
  logic [15:0] rid = '0;
  logic [63:0] raddr = '0;
  logic        crdy = 1'b0;
  logic [3:0]  req_ready;
  logic        cmd_valid, cmd_write, cmd_hi;
  logic [3:0]  cmd_id;
  logic [15:0] cmd_addr;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [19:0] hq[$], wq[$], lq[$];
  int am[3] = '{0, 0, 0};
  int rr_m = 0;
  int acc_cnt[4] = '{0, 0, 0, 0};

  always #10 clk = ~clk;

  mem_req_sched dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_hi_port(hi_port), .cfg_hi_slots(hi_slots),
    .cfg_lvl_hi(lv_hi), .cfg_lvl_wr(lv_wr), .cfg_lvl_lo(lv_lo),
    .req_valid(rv), .req_write(rw), .req_id(rid), .req_addr(raddr),
    .req_ready(req_ready), .cmd_valid(cmd_valid), .cmd_ready(crdy),
    .cmd_write(cmd_write), .cmd_hi(cmd_hi), .cmd_id(cmd_id), .cmd_addr(cmd_addr));

  task automatic chk(input bit ok, input string tag, input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  function automatic int qsize(int q);
    case (q) 0: return hq.size(); 1: return wq.size(); default: return lq.size(); endcase
  endfunction

  function automatic logic [19:0] qfront(int q);
    case (q) 0: return hq[0]; 1: return wq[0]; default: return lq[0]; endcase
  endfunction

  function automatic int dst(int p);
    if (rw[p]) return 1;
    return hi_port[p] ? 0 : 2;
  endfunction

  task automatic step();
    int hc, sel, pk, d, i;
    int cp[3], sz[3], lm[3];
    bit ac, anyc, cv, gr;
    bit nz[3], cr[3];
    logic [3:0] er;
    logic [19:0] hd;
    hc = (hi_slots > 32) ? 32 : int'(hi_slots);
    cp[0] = hc; cp[1] = 16; cp[2] = 32 - hc;
    for (int q = 0; q < 3; q++) sz[q] = qsize(q);
    ac = 0; sel = 0;
    for (int k = 0; k < 4; k++) begin
      i = (rr_m + k) % 4;
      d = dst(i);
      if (!ac && rv[i] && sz[d] < cp[d]) begin ac = 1; sel = i; end
    end
    er = ac ? 4'(1 << sel) : 4'd0;
    chk(req_ready === er, "R7 R3 admission ready", 64'(req_ready), 64'(er));
    lm[0] = lv_hi * 32; lm[1] = lv_wr * 32; lm[2] = lv_lo * 32;
    anyc = 0;
    for (int q = 0; q < 3; q++) begin
      nz[q] = sz[q] > 0;
      cr[q] = nz[q] && am[q] >= lm[q];
      anyc |= cr[q];
    end
    pk = -1;
    for (int q = 0; q < 3; q++) if (pk < 0 && (anyc ? cr[q] : nz[q])) pk = q;
    cv = pk >= 0;
    chk(cmd_valid === cv, "R6 R9 command valid", 64'(cmd_valid), 64'(cv));
    if (cv) begin
      hd = qfront(pk);
      chk({cmd_write, cmd_hi} === {pk == 1, pk == 0}, "R2 R5 R6 queue choice",
          64'({cmd_write, cmd_hi}), 64'({pk == 1, pk == 0}));
      chk({cmd_id, cmd_addr} === hd, "R8 head id/addr", 64'({cmd_id, cmd_addr}), 64'(hd));
    end
    if (ac) acc_cnt[sel]++;
    for (int q = 0; q < 3; q++) begin
      gr = cv && crdy && pk == q;
      if (gr || sz[q] == 0) am[q] = 0;
      else if (am[q] < 1023) am[q]++;
    end
    if (cv && crdy) begin
      case (pk) 0: void'(hq.pop_front()); 1: void'(wq.pop_front()); default: void'(lq.pop_front()); endcase
    end
    if (ac) begin
      hd = {rid[sel*4 +: 4], raddr[sel*16 +: 16]};
      case (dst(sel)) 0: hq.push_back(hd); 1: wq.push_back(hd); default: lq.push_back(hd); endcase
      rr_m = (sel + 1) % 4;
    end
  endtask

  always @(negedge clk) begin
    #9;
    if (rst_n && !done) step();
  end

  task automatic clear_counts();
    for (int p = 0; p < 4; p++) acc_cnt[p] = 0;
  endtask

  task automatic drain();
    @(negedge clk); #1;
    rv = '0; rw = '0; crdy = 1'b1;
    repeat (100) @(negedge clk);
    #1 crdy = 1'b0;
  endtask

  task automatic hold_reads(input logic [3:0] v, input logic [3:0] w, input int n);
    @(negedge clk); #1;
    clear_counts();
    rv = v; rw = w; crdy = 1'b0;
    rid = 16'hA5C3; raddr = 64'h1111_2222_3333_4444;
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic random_run(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk); #1;
      rv = 4'($urandom); rw = 4'($urandom); rid = 16'($urandom);
      raddr = {$urandom, $urandom}; crdy = ($urandom % 4) != 0;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int first;
    #15;
    chk(cmd_valid === 1'b0, "R1 cmd_valid in reset", 64'(cmd_valid), 0);
    chk(req_ready === 4'd0, "R1 req_ready in reset", 64'(req_ready), 0);
    #30 rst_n = 1'b1;

    // R7: all ports with room, rotation gives each port two grants in 8 cycles
    hi_port = 4'b1111; hi_slots = 6'd32;
    hold_reads(4'b1111, 4'b0000, 8);
    for (int p = 0; p < 4; p++) chk(acc_cnt[p] == 2, "R7 round-robin share", 64'(acc_cnt[p]), 2);
    drain();

    // R3: 24 urgent, 8 background, 16 write entries
    hi_port = 4'b1000; hi_slots = 6'd24;
    hold_reads(4'b1011, 4'b0010, 80);
    chk(acc_cnt[3] == 24, "R3 urgent share", 64'(acc_cnt[3]), 24);
    chk(acc_cnt[0] == 8, "R3 background share", 64'(acc_cnt[0]), 8);
    chk(acc_cnt[1] == 16, "R3 write depth", 64'(acc_cnt[1]), 16);
    chk(req_ready === 4'd0, "R3 backpressure when full", 64'(req_ready), 0);
    drain();

    // R4: 40 acts as 32, background reads get nothing
    hi_slots = 6'd40;
    hold_reads(4'b1001, 4'b0000, 60);
    chk(acc_cnt[0] == 0, "R4 clamp leaves no background entries", 64'(acc_cnt[0]), 0);
    chk(acc_cnt[3] == 32, "R4 clamp gives 32 urgent entries", 64'(acc_cnt[3]), 32);
    drain();

    // R5 R6: background read with level 1 overtakes busy urgent queue after 32 cycles
    hi_slots = 6'd24; lv_hi = 4'd15; lv_wr = 4'd15; lv_lo = 4'd1;
    @(negedge clk); #1;
    rv = 4'b1000; rid = 16'h7005; raddr = 64'h0000_0000_0000_BEEF; crdy = 1'b0;
    repeat (4) @(negedge clk);
    #1 rv = 4'b0001;
    @(negedge clk); #1;
    rv = 4'b1000; crdy = 1'b1; first = -1;
    for (int k = 1; k <= 40; k++) begin
      #7;
      if (first < 0 && cmd_valid && !cmd_write && !cmd_hi) first = k;
      @(negedge clk); #1;
    end
    chk(first == 33, "R5 R6 critical background issue cycle", 64'(first), 33);
    drain();

    lv_hi = 4'd2; lv_wr = 4'd15; lv_lo = 4'd15;
    random_run(400);
    drain();
    hi_port = 4'b0101; hi_slots = 6'd8; lv_hi = 4'd0; lv_wr = 4'd3; lv_lo = 4'd1;
    random_run(400);
    drain();
    hi_port = 4'b0000; hi_slots = 6'd0; lv_hi = 4'd1; lv_wr = 4'd1; lv_lo = 4'd1;
    random_run(300);
    drain();
    chk(cmd_valid === 1'b0, "R9 idle after drain", 64'(cmd_valid), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule